// File: doc/BRIEF.md
# Shared-Datapath Lifting Wavelet Engine

This block computes a single-level one-dimensional discrete wavelet transform for many interleaved recording channels. It uses a lifting factorization with four vanishing moments. Each transaction on the input carries one even/odd sample pair and the index of the channel it belongs to. One multiply-add unit then works through the lifting chain one step per clock cycle, under a small step counter. After that the engine presents the detail coefficient and then the approximation coefficient, each tagged with its channel.

Every step has the same form. The engine takes a base value and adds a rounded product: a 5-bit signed coefficient times the sum of two operands. One operand is a current partial value. The other is that channel's partial value from its previous pair, read from a small per-channel history store. Results are held in 10-bit signed fixed point. Because of this, channels can be interleaved pair by pair, and each channel still sees a continuous signal. Reset clears the history, which pads every channel with zeros at its start.

Top module: `lwt_core`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A pair is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is then 0 until the approximation output has been shown. It returns to 1 exactly 8 cycles after the accepting edge.
- R3: The detail coefficient appears for exactly one cycle, 6 cycles after the accepting edge, with `out_valid`=1 and `out_is_detail`=1. The approximation appears in the following cycle with `out_is_detail`=0. Both carry the accepted `in_chan` on `out_chan`.
- R4: With coefficients c0..c5 = -3, 2, -5, 1, 11, 6 in eighths, and history h0..h3 of the same channel, the steps run in this order: d=o+R(c0(e+h0)); s=e+R(c1(d+h1)); d=d+R(c2(s+h2)); s=s+R(c3(d+h3)); s=R(c4·s); d=R(c5·d). Each step saturates.
- R5: R(p) rounds to nearest with ties toward plus infinity, that is floor((p+4)/8). Example: a fresh channel with e=4, o=0 gives detail -2 and approximation 6.
- R6: Every step result is clamped to [-512, 511] and never wraps.
- R7: After a pair of channel c, that channel's history becomes h0=e, h1=d after the first step, h2=s after the second, h3=d after the third. Pairs of other channels do not change it.
- R8: After reset every channel's history is zero.
- R9: `in_valid` pulses while `in_ready` is 0 are ignored. They produce no output and do not change the pending result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pair present |
| in_ready | output | 1 | Engine idle, can accept a pair |
| in_chan | input | CHW | Channel index of the input pair |
| in_even | input | DW | Even sample, signed |
| in_odd | input | DW | Odd sample, signed |
| out_valid | output | 1 | Coefficient present |
| out_is_detail | output | 1 | 1 = detail, 0 = approximation |
| out_chan | output | CHW | Channel of the coefficient |
| out_coef | output | DW | Coefficient value, signed |

## Verification
A fresh channel driven with a small hand-computed pair separates round-half-up from truncation and from floor rounding. A repeated full-scale pair with opposite signs drives the first predict step past the 10-bit range, so clamping is told apart from wrap-around. A long run that interleaves channels in a scrambled order, compared against a bit-exact model, exposes any history that is read from or written to the wrong channel, or written with the wrong partial value. A busy-time `in_valid` pulse carrying garbage shows whether the sequencer wrongly captures data while it runs.

// File: rtl/lwt_pkg.sv
package lwt_pkg;

    localparam int COEF_W    = 5;
    localparam int COEF_FRAC = 3;
    localparam int NUM_STEPS = 6;
    localparam int STEP_W    = $clog2(NUM_STEPS);
    localparam int NUM_TAPS  = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_RUN,
        SEQ_EMIT_D,
        SEQ_EMIT_A
    } seq_state_e;

    // Quantized lifting constants, value = code / 2**COEF_FRAC
    function automatic logic signed [COEF_W-1:0] step_coef(input logic [STEP_W-1:0] k);
        logic signed [COEF_W-1:0] c;
        case (k)
            3'd0:    c = -5'sd3;
            3'd1:    c = 5'sd2;
            3'd2:    c = -5'sd5;
            3'd3:    c = 5'sd1;
            3'd4:    c = 5'sd11;
            3'd5:    c = 5'sd6;
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lwt_mac.sv
module lwt_mac #(
    parameter int DW   = 10,
    parameter int CW   = 5,
    parameter int FRAC = 3
) (
    input  logic signed [DW-1:0] base_i,
    input  logic signed [DW-1:0] opa_i,
    input  logic signed [DW-1:0] opb_i,
    input  logic signed [CW-1:0] coef_i,
    output logic signed [DW-1:0] res_o
);
    localparam int PW   = DW + 1 + CW;
    localparam int HALF = 1 << (FRAC - 1);
    localparam int MAXV = (1 << (DW - 1)) - 1;
    localparam int MINV = -(1 << (DW - 1));

    logic signed [DW:0]   sum;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;
    logic signed [PW:0]   tot;

    always_comb begin
        sum  = (DW+1)'(opa_i) + (DW+1)'(opb_i);
        prod = PW'(sum) * PW'(coef_i);
        rnd  = (prod + PW'(HALF)) >>> FRAC;
        tot  = (PW+1)'(base_i) + (PW+1)'(rnd);
        if (tot > (PW+1)'(MAXV))
            res_o = DW'(MAXV);
        else if (tot < (PW+1)'(MINV))
            res_o = DW'(MINV);
        else
            res_o = tot[DW-1:0];
    end
endmodule

// File: rtl/lwt_hist_mem.sv
module lwt_hist_mem #(
    parameter int NCH  = 8,
    parameter int DW   = 10,
    parameter int NTAP = 4,
    localparam int CHW = $clog2(NCH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [CHW-1:0]                 rd_ch,
    output logic [NTAP-1:0][DW-1:0]        rd_data,
    input  logic                           wr_en,
    input  logic [CHW-1:0]                 wr_ch,
    input  logic [NTAP-1:0][DW-1:0]        wr_data
);
    logic [NCH-1:0][NTAP-1:0][DW-1:0] mem_d, mem_q;

    for (genvar g = 0; g < NCH; g++) begin : g_row
        always_comb begin
            mem_d[g] = mem_q[g];
            if (wr_en && wr_ch == CHW'(g))
                mem_d[g] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rd_data = mem_q[rd_ch];
endmodule

// File: rtl/lwt_seq.sv
module lwt_seq
    import lwt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              accept,
    output logic              run,
    output logic [STEP_W-1:0] step,
    output logic              emit_d,
    output logic              emit_a
);
    typedef struct packed {
        seq_state_e        st;
        logic [STEP_W-1:0] step;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            SEQ_IDLE: begin
                if (in_valid) begin
                    s_d.st   = SEQ_RUN;
                    s_d.step = '0;
                end
            end
            SEQ_RUN: begin
                if (s_q.step == STEP_W'(NUM_STEPS - 1)) begin
                    s_d.st   = SEQ_EMIT_D;
                    s_d.step = '0;
                end else begin
                    s_d.step = s_q.step + 1'b1;
                end
            end
            SEQ_EMIT_D: s_d.st = SEQ_EMIT_A;
            default:    s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SEQ_IDLE, step: '0};
        else        s_q <= s_d;
    end

    assign in_ready = (s_q.st == SEQ_IDLE);
    assign accept   = in_ready && in_valid;
    assign run      = (s_q.st == SEQ_RUN);
    assign step     = s_q.step;
    assign emit_d   = (s_q.st == SEQ_EMIT_D);
    assign emit_a   = (s_q.st == SEQ_EMIT_A);
endmodule

// File: rtl/lwt_core.sv
module lwt_core
    import lwt_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 10,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [CHW-1:0] in_chan,
    input  logic [DW-1:0]  in_even,
    input  logic [DW-1:0]  in_odd,
    output logic           out_valid,
    output logic           out_is_detail,
    output logic [CHW-1:0] out_chan,
    output logic [DW-1:0]  out_coef
);
    typedef logic [NUM_TAPS-1:0][DW-1:0] hist_t;

    typedef struct packed {
        logic [CHW-1:0] ch;
        logic [DW-1:0]  ev;
        logic [DW-1:0]  od;
        logic [DW-1:0]  ap;
        logic [DW-1:0]  dt;
        logic [DW-1:0]  n1;
        logic [DW-1:0]  n2;
        logic [DW-1:0]  n3;
        hist_t          h;
    } work_t;

    work_t w_d, w_q;

    logic              accept, run, emit_d, emit_a;
    logic [STEP_W-1:0] step;
    hist_t             rd_hist, wr_hist;
    logic [DW-1:0]     mac_base, mac_a, mac_b, mac_res;
    logic [COEF_W-1:0] mac_coef;

    lwt_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .accept   (accept),
        .run      (run),
        .step     (step),
        .emit_d   (emit_d),
        .emit_a   (emit_a)
    );

    lwt_hist_mem #(.NCH(NCH), .DW(DW), .NTAP(NUM_TAPS)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_ch   (in_chan),
        .rd_data (rd_hist),
        .wr_en   (emit_a),
        .wr_ch   (w_q.ch),
        .wr_data (wr_hist)
    );

    lwt_mac #(.DW(DW), .CW(COEF_W), .FRAC(COEF_FRAC)) u_mac (
        .base_i (mac_base),
        .opa_i  (mac_a),
        .opb_i  (mac_b),
        .coef_i (mac_coef),
        .res_o  (mac_res)
    );

    // Operand routing for the shared multiply-add
    always_comb begin
        mac_base = '0;
        mac_a    = '0;
        mac_b    = '0;
        mac_coef = step_coef(step);
        case (step)
            3'd0: begin mac_base = w_q.od; mac_a = w_q.ev; mac_b = w_q.h[0]; end
            3'd1: begin mac_base = w_q.ev; mac_a = w_q.dt; mac_b = w_q.h[1]; end
            3'd2: begin mac_base = w_q.dt; mac_a = w_q.ap; mac_b = w_q.h[2]; end
            3'd3: begin mac_base = w_q.ap; mac_a = w_q.dt; mac_b = w_q.h[3]; end
            3'd4: mac_a = w_q.ap;
            3'd5: mac_a = w_q.dt;
            default: ;
        endcase
    end

    always_comb begin
        w_d = w_q;
        if (accept) begin
            w_d.ch = in_chan;
            w_d.ev = in_even;
            w_d.od = in_odd;
            w_d.h  = rd_hist;
        end
        if (run) begin
            case (step)
                3'd0: begin w_d.dt = mac_res; w_d.n1 = mac_res; end
                3'd1: begin w_d.ap = mac_res; w_d.n2 = mac_res; end
                3'd2: begin w_d.dt = mac_res; w_d.n3 = mac_res; end
                3'd3: w_d.ap = mac_res;
                3'd4: w_d.ap = mac_res;
                3'd5: w_d.dt = mac_res;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    always_comb begin
        wr_hist[0] = w_q.ev;
        wr_hist[1] = w_q.n1;
        wr_hist[2] = w_q.n2;
        wr_hist[3] = w_q.n3;
    end

    assign out_valid     = emit_d || emit_a;
    assign out_is_detail = emit_d;
    assign out_chan      = w_q.ch;
    assign out_coef      = emit_d ? w_q.dt : w_q.ap;
endmodule

// File: rtl/lwt_core_chk.sv
module lwt_core_chk #(
    parameter int CHW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           in_ready,
    input logic           out_valid,
    input logic           out_is_detail,
    input logic [CHW-1:0] out_chan
);
    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R2
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R2
    AST_READY_AFTER_APPROX: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_detail) |=> in_ready); // R2
    AST_DETAIL_THEN_APPROX: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_detail) |=> (out_valid && !out_is_detail)); // R3
    AST_APPROX_AFTER_DETAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_detail) |-> $past(out_valid && out_is_detail)); // R3
    AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_detail) |-> $stable(out_chan)); // R3
endmodule

bind lwt_core lwt_core_chk #(.CHW(CHW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_is_detail (out_is_detail),
    .out_chan      (out_chan)
);

// File: tb/lwt_core_tb.sv
module lwt_core_tb;
    localparam int NCH = 8;
    localparam int DW  = 10;
    localparam int CHW = $clog2(NCH);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [CHW-1:0] in_chan = '0;
    logic [DW-1:0]  in_even = '0;
    logic [DW-1:0]  in_odd = '0;
    logic           out_valid, out_is_detail;
    logic [CHW-1:0] out_chan;
    logic [DW-1:0]  out_coef;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int hist [NCH][4];
    int coef [6] = '{-3, 2, -5, 1, 11, 6};

    always #4 clk = ~clk;

    lwt_core #(.NCH(NCH), .DW(DW)) u_dut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rnd8(input int p);
        return (p + 4) >>> 3;
    endfunction

    function automatic int clamp(input int v);
        return (v > 511) ? 511 : (v < -512) ? -512 : v;
    endfunction

    // Bit-exact model of the lifting chain (R4, R5, R6, R7)
    task automatic model(input int ch, input int e, input int o, output int dd, output int aa);
        int d1, s1, d2, s2;
        d1 = clamp(o + rnd8(coef[0] * (e + hist[ch][0])));
        s1 = clamp(e + rnd8(coef[1] * (d1 + hist[ch][1])));
        d2 = clamp(d1 + rnd8(coef[2] * (s1 + hist[ch][2])));
        s2 = clamp(s1 + rnd8(coef[3] * (d2 + hist[ch][3])));
        aa = clamp(rnd8(coef[4] * s2));
        dd = clamp(rnd8(coef[5] * d2));
        hist[ch][0] = e; hist[ch][1] = d1; hist[ch][2] = s1; hist[ch][3] = d2;
    endtask

    // Sends one pair (caller is at a negedge) and checks timing and values
    task automatic send_pair(input int ch, input int e, input int o, input bit glitch,
                             input string req, output int dd, output int aa);
        model(ch, e, o, dd, aa);
        in_chan = CHW'(ch); in_even = DW'(e); in_odd = DW'(o); in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(!in_ready, "R2", int'(in_ready), 0);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (glitch && k == 2) begin
                in_valid = 1'b1; in_chan = CHW'(ch + 1); in_even = 10'h155; in_odd = 10'h2AA;
            end
            if (glitch && k == 3) in_valid = 1'b0;
            if (k == 5) check(!out_valid, "R3", int'(out_valid), 0);
        end
        check(out_valid && out_is_detail, "R3", int'({out_valid, out_is_detail}), 3);
        check(int'(out_chan) == ch, "R3", int'(out_chan), ch);
        check($signed(out_coef) == dd, req, $signed(out_coef), dd);
        @(negedge clk);
        check(out_valid && !out_is_detail, "R3", int'({out_valid, out_is_detail}), 2);
        check(int'(out_chan) == ch, "R3", int'(out_chan), ch);
        check($signed(out_coef) == aa, req, $signed(out_coef), aa);
        check(!in_ready, "R2", int'(in_ready), 0);
        @(negedge clk);
        check(in_ready, "R2", int'(in_ready), 1);
        check(!out_valid, glitch ? "R9" : "R2", int'(out_valid), 0);
    endtask

    task automatic test_reset();
        check(in_ready, "R1", int'(in_ready), 1);
        check(!out_valid, "R1", int'(out_valid), 0);
    endtask

    task automatic test_rounding();
        int dd, aa;
        // fresh channel: zero history (R8), ties round upward (R5)
        send_pair(3, 4, 0, 1'b0, "R5", dd, aa);
        check(dd == -2, "R5", dd, -2);
        check(aa == 6, "R5", aa, 6);
    endtask

    task automatic test_saturation();
        int dd, aa;
        send_pair(5, 511, -512, 1'b0, "R6", dd, aa);
        send_pair(5, 511, -512, 1'b0, "R6", dd, aa);
        send_pair(5, -512, 511, 1'b0, "R6", dd, aa);
        send_pair(5, -512, 511, 1'b0, "R6", dd, aa);
    endtask

    task automatic test_interleave();
        int dd, aa, ch, e, o;
        for (int i = 0; i < 40; i++) begin
            ch = (i * 5 + i / 8) % NCH;
            e  = ((i * 173 + ch * 59) % 1024) - 512;
            o  = ((i * 97 + ch * 211 + 300) % 1024) - 512;
            send_pair(ch, e, o, 1'b0, "R7", dd, aa); // R4 R7
        end
    endtask

    task automatic test_busy_ignore();
        int dd, aa;
        send_pair(1, 100, -37, 1'b1, "R9", dd, aa);
        send_pair(2, -200, 150, 1'b0, "R7", dd, aa); // channel 2 unaffected by the glitch
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_rounding();
        test_saturation();
        test_busy_ignore();
        test_interleave();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule